// File: doc/BRIEF.md
# Operand Bus-Sizing Transfer Sequencer

This block sits between a CPU load/store path and a 16-bit external data port. The CPU asks for a byte, word or long-word operand, and the block turns that request into one or two external bus cycles. For each cycle it drives the word address, the low address bit and a two-bit remaining-bytes code. On writes it places operand bytes on the two data lanes. On reads it gathers the returned data into a 32-bit operand register. A word or long word at an odd address is refused with an address-error pulse and starts no bus cycle.

The CPU side is a valid/ready stream. The CPU holds `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge. The request is taken in that cycle. `req_ready` is high only while the sequencer is idle, so a busy sequencer applies back-pressure simply by holding it low. The response side cannot be stalled: `rsp_ack` and `rsp_addr_err` are one-clock pulses. The external side holds `bus_cyc` and its qualifiers until the port returns `bus_done` for one clock.

Request size codes are 01 (byte), 10 (word) and 00 (long word). Code 11 is not a valid request.

Top module: `opsz_seq`

## Requirements
- R1: `req_ready` is high exactly when no bus cycle is active and no request is in flight. A request is accepted on a clock where `req_valid` and `req_ready` are both high.
- R2: A request is refused in either of two cases: size 10 or 00 with `req_addr[0]`=1, or size 11 at any address. On the next clock, a refused request pulses `rsp_addr_err` for one clock. It starts no bus cycle and produces no `rsp_ack`.
- R3: A byte request (size 01) at any address runs one bus cycle with `bus_siz`=01 and `bus_addr` equal to the request address.
- R4: An aligned word request (size 10) runs one bus cycle with `bus_siz`=10 at the request address.
- R5: An aligned long-word request (size 00) runs two bus cycles. The first has `bus_siz`=00 at the base address. The second has `bus_siz`=10 at base+2 and begins on the clock right after the first cycle's `bus_done`.
- R6: While `bus_cyc` is high and `bus_done` is low, `bus_addr`, `bus_siz`, `bus_rw` and `bus_dout` hold their values into the next clock. `bus_rw` is 1 for a read and 0 for a write.
- R7: Write lanes are placed as follows:
  - word: `bus_dout` = wdata[15:0];
  - long word: wdata[31:16] in the first cycle, then wdata[15:0];
  - byte: wdata[7:0] copied onto both [15:8] and [7:0].
- R8: Read data is assembled as follows:
  - long word: first returned word to `rsp_rdata`[31:16], second to [15:0];
  - word: returned word to [15:0], with the upper half zero;
  - byte: `bus_din`[15:8] for an even address or `bus_din`[7:0] for an odd one goes to [7:0], with the rest zero.
- R9: `rsp_ack` is high for exactly one clock, on the clock after the final cycle's `bus_done`. `rsp_rdata` is valid in that clock for reads.
- R10: During reset, `bus_cyc`, `rsp_ack` and `rsp_addr_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 01 byte, 10 word, 00 long word |
| req_addr | input | ADDR_W | Operand byte address |
| req_wdata | input | 32 | Store operand, right-justified |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_addr_err | output | 1 | One-clock misalignment / bad-size pulse |
| rsp_rdata | output | 32 | Assembled load operand |
| bus_cyc | output | 1 | External cycle in progress |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | ADDR_W | Cycle address, bit 0 is the byte offset |
| bus_siz | output | 2 | Bytes still to move: 01=1, 10=2, 11=3, 00=4 |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_done | input | 1 | Port finished the current cycle |

## Verification
The bench drives odd-address words and long words and expects an error pulse with no cycle at all. A sequencer that checked alignment late would show a stray `bus_cyc`. A long-word transfer must show the 00 code first and then 10 at base+2. A design that encoded the width of the current cycle would show 10 twice, and one that swapped halves would return a rotated operand. Byte reads at even and odd addresses separate a correct lane pick from a swapped one. Byte writes must show the byte on both lanes. Varying the port's delay before `bus_done` exposes an acknowledge that fires early or lasts more than one clock.

// File: rtl/opsz_pkg.sv
package opsz_pkg;
  localparam int OP_W   = 32;
  localparam int PORT_W = 16;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_LONG  = 2'b00,
    SZ_BYTE  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_THREE = 2'b11
  } opsz_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND
  } seq_st_e;
endpackage

// File: rtl/opsz_ctrl.sv
module opsz_ctrl
  import opsz_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  opsz_e req_size,
  input  logic  req_addr0,
  input  logic  bus_done,
  output logic  req_ready,
  output logic  accept,
  output logic  bus_cyc,
  output logic  phase2,
  output logic  capture,
  output logic  capture_hi,
  output logic  rsp_ack,
  output logic  rsp_addr_err
);
  seq_st_e state_q;
  logic    is_long_q;
  logic    ack_q, err_q;
  logic    bad_req, reject, final_done;

  assign bad_req    = (req_size == SZ_THREE) || ((req_size != SZ_BYTE) && req_addr0);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready && req_valid && !bad_req;
  assign reject     = req_ready && req_valid && bad_req;
  assign bus_cyc    = (state_q != ST_IDLE);
  assign phase2     = (state_q == ST_SECOND);
  assign capture    = bus_cyc && bus_done;
  assign capture_hi = capture && (state_q == ST_FIRST) && is_long_q;
  assign final_done = capture && ((state_q == ST_SECOND) || !is_long_q);
  assign rsp_ack      = ack_q;
  assign rsp_addr_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      is_long_q <= 1'b0;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ack_q <= final_done;
      err_q <= reject;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_FIRST;
          is_long_q <= (req_size == SZ_LONG);
        end
        ST_FIRST:  if (bus_done) state_q <= is_long_q ? ST_SECOND : ST_IDLE;
        ST_SECOND: if (bus_done) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REJECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (rsp_addr_err && !bus_cyc)); // R2
  AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr_err |-> !rsp_ack); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> (req_ready && !bus_cyc)); // R1
endmodule

// File: rtl/opsz_lane_mux.sv
module opsz_lane_mux
  import opsz_pkg::*;
(
  input  opsz_e              size,
  input  logic               phase2,
  input  logic [OP_W-1:0]    wdata,
  output logic [PORT_W-1:0]  dout
);
  always_comb begin
    if (size == SZ_BYTE)
      dout = {2{wdata[LANE_W-1:0]}};
    else if ((size == SZ_LONG) && !phase2)
      dout = wdata[OP_W-1:PORT_W];
    else
      dout = wdata[PORT_W-1:0];
  end
endmodule

// File: rtl/opsz_rd_merge.sv
module opsz_rd_merge
  import opsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              capture_hi,
  input  logic              byte_mode,
  input  logic              addr0,
  input  logic [PORT_W-1:0] din,
  output logic [OP_W-1:0]   rdata
);
  logic [OP_W-1:0]   opreg_q;
  logic [LANE_W-1:0] picked;

  assign picked = addr0 ? din[LANE_W-1:0] : din[PORT_W-1:LANE_W];
  assign rdata  = opreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      opreg_q <= '0;
    else if (clear)
      opreg_q <= '0;
    else if (capture) begin
      if (capture_hi)
        opreg_q[OP_W-1:PORT_W] <= din;
      else if (byte_mode)
        opreg_q[LANE_W-1:0] <= picked;
      else
        opreg_q[PORT_W-1:0] <= din;
    end
  end
endmodule

// File: rtl/opsz_seq.sv
module opsz_seq
  import opsz_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ack,
  output logic              rsp_addr_err,
  output logic [31:0]       rsp_rdata,
  output logic              bus_cyc,
  output logic              bus_rw,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din,
  input  logic              bus_done
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(PORT_W / LANE_W);

  opsz_e             size_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OP_W-1:0]   wdata_q;
  logic              accept, phase2, capture, capture_hi;

  opsz_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_size(opsz_e'(req_size)), .req_addr0(req_addr[0]), .bus_done(bus_done),
    .req_ready(req_ready), .accept(accept), .bus_cyc(bus_cyc), .phase2(phase2),
    .capture(capture), .capture_hi(capture_hi),
    .rsp_ack(rsp_ack), .rsp_addr_err(rsp_addr_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      size_q  <= opsz_e'(req_size);
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign bus_rw   = !write_q;
  assign bus_siz  = phase2 ? SZ_WORD : size_q;
  assign bus_addr = phase2 ? (addr_q + WORD_STEP) : addr_q;

  opsz_lane_mux u_mux (
    .size(size_q), .phase2(phase2), .wdata(wdata_q), .dout(bus_dout)
  );

  opsz_rd_merge u_merge (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture(capture),
    .capture_hi(capture_hi), .byte_mode(size_q == SZ_BYTE), .addr0(addr_q[0]),
    .din(bus_din), .rdata(rsp_rdata)
  );

  AST_HOLD_QUALIFIERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_done) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz)
                                && $stable(bus_rw) && $stable(bus_dout))); // R6
  AST_LONG_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_done && bus_siz == 2'b00) |=>
      (bus_cyc && bus_siz == 2'b10 && bus_addr == $past(bus_addr) + WORD_STEP)); // R5
  AST_BYTE_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rw && bus_siz == 2'b01) |-> (bus_dout[15:8] == bus_dout[7:0])); // R7
  AST_NO_ODD_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_siz != 2'b01) |-> !bus_addr[0]); // R2
endmodule

// File: tb/tb_opsz_seq.sv
module tb_opsz_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b01;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_ack, rsp_addr_err, bus_cyc, bus_rw;
  logic [31:0] rsp_rdata;
  logic [23:0] bus_addr;
  logic [1:0]  bus_siz;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_done = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  opsz_seq #(.ADDR_W(24)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: computes the cycle list and final operand per request.
  task automatic run_req(input bit wr, input logic [1:0] sz, input logic [23:0] ad,
                         input logic [31:0] wd, input logic [15:0] d0, input logic [15:0] d1,
                         input int dly);
    bit bad;
    int n;
    logic [31:0] exp_rd;
    logic [23:0] ea;
    logic [1:0]  es;
    logic [15:0] ed;
    bad = (sz == 2'b11) || (sz != 2'b01 && ad[0]);
    n   = (sz == 2'b00) ? 2 : 1;
    if (sz == 2'b00)      exp_rd = {d0, d1};
    else if (sz == 2'b10) exp_rd = {16'h0, d0};
    else                  exp_rd = {24'h0, ad[0] ? d0[7:0] : d0[15:8]};
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
    chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(rsp_addr_err == 1'b1, "R2 error pulse", 32'(rsp_addr_err), 32'd1);
      chk(bus_cyc == 1'b0, "R2 no bus cycle", 32'(bus_cyc), 32'd0);
      chk(rsp_ack == 1'b0, "R2 no ack", 32'(rsp_ack), 32'd0);
      @(negedge clk);
      chk(rsp_addr_err == 1'b0, "R2 error one clock", 32'(rsp_addr_err), 32'd0);
      chk(bus_cyc == 1'b0, "R2 still no cycle", 32'(bus_cyc), 32'd0);
      return;
    end
    for (int c = 0; c < n; c++) begin
      ea = ad + 24'(2 * c);
      es = (n == 2) ? ((c == 0) ? 2'b00 : 2'b10) : sz;
      if (sz == 2'b01)               ed = {2{wd[7:0]}};
      else if (n == 2 && c == 0)     ed = wd[31:16];
      else                           ed = wd[15:0];
      for (int k = 0; k <= dly; k++) begin
        chk(bus_cyc == 1'b1, "R5 cycle active", 32'(bus_cyc), 32'd1);
        chk(req_ready == 1'b0, "R1 busy not ready", 32'(req_ready), 32'd0);
        chk(bus_addr == ea, "R3 R4 R5 address", 32'(bus_addr), 32'(ea));
        chk(bus_siz == es, "R3 R4 R5 size code", 32'(bus_siz), 32'(es));
        chk(bus_rw == !wr, "R6 direction", 32'(bus_rw), 32'(!wr));
        if (wr) chk(bus_dout == ed, "R7 write lanes", 32'(bus_dout), 32'(ed));
        chk(rsp_ack == 1'b0, "R9 no early ack", 32'(rsp_ack), 32'd0);
        if (k < dly) @(negedge clk);
      end
      bus_done = 1'b1;
      bus_din  = (c == 0) ? d0 : d1;
      @(negedge clk);
      bus_done = 1'b0;
      bus_din  = 16'hDEAD;
    end
    chk(rsp_ack == 1'b1, "R9 ack after final cycle", 32'(rsp_ack), 32'd1);
    chk(bus_cyc == 1'b0, "R9 bus idle at ack", 32'(bus_cyc), 32'd0);
    if (!wr) chk(rsp_rdata == exp_rd, "R8 read operand", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R9 ack one clock", 32'(rsp_ack), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cyc == 1'b0, "R10 reset no cycle", 32'(bus_cyc), 32'd0);
    chk(rsp_ack == 1'b0, "R10 reset no ack", 32'(rsp_ack), 32'd0);
    chk(rsp_addr_err == 1'b0, "R10 reset no error", 32'(rsp_addr_err), 32'd0);
    chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // Byte reads at even and odd addresses (R3, R8)
    run_req(1'b0, 2'b01, 24'h001000, '0, 16'hA1B2, 16'h0, 0);
    run_req(1'b0, 2'b01, 24'h001001, '0, 16'hA1B2, 16'h0, 2);
    // Byte writes, both lanes (R7)
    run_req(1'b1, 2'b01, 24'h002003, 32'h123456C3, '0, '0, 1);
    run_req(1'b1, 2'b01, 24'h002004, 32'h0000005A, '0, '0, 0);
    // Word read and write (R4)
    run_req(1'b0, 2'b10, 24'h003010, '0, 16'hBEEF, 16'h0, 3);
    run_req(1'b1, 2'b10, 24'h003012, 32'hFFFF7E81, '0, '0, 0);
    // Long word read and write (R5)
    run_req(1'b0, 2'b00, 24'h00FFFE, '0, 16'h1357, 16'h9BDF, 1);
    run_req(1'b1, 2'b00, 24'h004000, 32'hCAFEF00D, '0, '0, 2);
    run_req(1'b0, 2'b00, 24'h004008, '0, 16'h0F0F, 16'hF0F0, 0);
    // Refused requests (R2)
    run_req(1'b0, 2'b10, 24'h005001, '0, '0, '0, 0);
    run_req(1'b1, 2'b00, 24'h005003, 32'h11111111, '0, '0, 0);
    run_req(1'b0, 2'b11, 24'h005000, '0, '0, '0, 0);
    // Back to back after an error, then a read clears old upper data (R8)
    run_req(1'b0, 2'b10, 24'h006000, '0, 16'h4242, 16'h0, 1);
    repeat (2) @(negedge clk);
    chk(bus_cyc == 1'b0 && rsp_ack == 1'b0, "R1 idle without request", 32'(bus_cyc), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule